// File: doc/BRIEF.md
# Control register update unit

This block holds the two processor control registers that govern operating mode and paging (CR0 and CR4) and keeps a set of hidden mode flags consistent with them. Every accepted write recomputes the flags that the rest of the core consumes directly: protected mode, the segment-base-addition flag used in real mode, the three floating-point trap flags, the OS FXSR enable, long-mode active and 64-bit code segment. The block also owns the long-mode-active bit of EFER.

A CR0 write that turns paging on while EFER.LME is set enters long mode, provided CR4.PAE is already set; without PAE that write is discarded. A CR0 write that turns paging off while long mode is active leaves long mode, clears the 64-bit code-segment flag and emits a strobe carrying the instruction pointer truncated to 32 bits. Writes that change a paging-relevant bit raise a one-cycle TLB-flush request. When both registers are written in the same cycle, the CR4 write takes effect first so a long-mode entry sees the new PAE value. All outputs are registered and change on the clock edge that accepts the write.

Top module: `ctl_reg_update`

## Requirements
- R1: After reset CR0 reads 0x60000010, CR4 reads 0, peFlag=0, addSegFlag=1, fpuFlags=0, osFxsrFlag=0, eferLma=0, cs64Flag=0, tlbFlush=0, ipTruncStrobe=0.
- R2: Bit 4 of the stored CR0 is always 1, whatever value is written; all other bits are stored as written when the write is accepted.
- R3: peFlag follows CR0 bit 0 after every accepted CR0 write; a write with bit 0 = 0 sets addSegFlag to 1, a write with bit 0 = 1 leaves addSegFlag unchanged.
- R4: fpuFlags = {TS, EM, MP} taken from CR0 bits 3, 2 and 1 of the accepted write (fpuFlags[0] is bit 1).
- R5: A CR0 write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) makes tlbFlush high for exactly the cycle after the write edge; a CR0 write that changes none of them leaves tlbFlush low.
- R6: A CR4 write that changes bit 7 (global pages), bit 5 (PAE) or bit 4 (large pages) raises the same one-cycle flush; a CR4 write changing only other bits does not.
- R7: On a CR4 write, bit 9 (OS FXSR) is stored as 0 when sseSupported is 0, and osFxsrFlag equals the stored bit 9.
- R8: A CR0 write taking bit 31 from 0 to 1 with eferLme=1 and CR4 bit 5 = 1 sets eferLma; with eferLme=0 eferLma stays 0.
- R9: A CR0 write taking bit 31 from 0 to 1 with eferLme=1 and CR4 bit 5 = 0 is discarded: CR0, peFlag, fpuFlags and eferLma keep their values (the flush request of R5 still follows the old/new comparison).
- R10: A CR0 write taking bit 31 from 1 to 0 while eferLma=1 clears eferLma and cs64Flag and pulses ipTruncStrobe for one cycle with ipTruncValue = ipIn with its upper 32 bits zeroed.
- R11: When CR0 and CR4 are written in the same cycle, the long-mode entry check of R8/R9 uses the newly written CR4 bit 5.
- R12: A csLongSet pulse sets cs64Flag only while eferLma=1; with eferLma=0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cr0WrEn | input | 1 | CR0 write strobe |
| cr0WrData | input | 32 | CR0 write value |
| cr4WrEn | input | 1 | CR4 write strobe |
| cr4WrData | input | 32 | CR4 write value |
| eferLme | input | 1 | EFER long-mode-enable bit |
| sseSupported | input | 1 | Strap: SSE present |
| csLongSet | input | 1 | Code segment loaded as 64-bit |
| ipIn | input | IP_W | Current instruction pointer |
| cr0Out | output | 32 | Stored CR0 |
| cr4Out | output | 32 | Stored CR4 |
| peFlag | output | 1 | Protected-mode hidden flag |
| addSegFlag | output | 1 | Segment-base-addition hidden flag |
| fpuFlags | output | 3 | {TS, EM, MP} hidden flags |
| osFxsrFlag | output | 1 | OS FXSR hidden flag |
| lmaFlag | output | 1 | Long-mode-active hidden flag |
| cs64Flag | output | 1 | 64-bit code-segment hidden flag |
| eferLma | output | 1 | EFER long-mode-active bit |
| tlbFlush | output | 1 | One-cycle TLB flush request |
| ipTruncStrobe | output | 1 | Instruction pointer truncation strobe |
| ipTruncValue | output | IP_W | Truncated instruction pointer |

## Verification
The hardest situation to reach is the long-mode entry that depends on a CR4 value written in the very same cycle: it only shows the CR4-first ordering when CR4.PAE is 0 beforehand, so the bench first proves a rejected entry with PAE clear, then issues the combined CR4 and CR0 write and expects long mode to become active. The exit path needs long mode and a 64-bit code segment to be established first, so the bench chains entry, a csLongSet pulse and the paging-off write with a recognisable instruction pointer whose upper half must vanish.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int CR_W      = 32;
  localparam int B_PE      = 0;
  localparam int B_MP      = 1;
  localparam int B_EM      = 2;
  localparam int B_TS      = 3;
  localparam int B_ET      = 4;
  localparam int B_WP      = 16;
  localparam int B_PG      = 31;
  localparam int B_PSE     = 4;
  localparam int B_PAE     = 5;
  localparam int B_PGE     = 7;
  localparam int B_OSFXSR  = 9;

  typedef struct packed {
    logic ld0;
    logic ld4;
    logic enterLm;
    logic exitLm;
    logic flush;
  } crStrobes_t;

  typedef struct packed {
    logic pe;
    logic addSeg;
    logic ts;
    logic em;
    logic mp;
  } cr0Flags_t;

  function automatic cr0Flags_t deriveFlags(input logic [CR_W-1:0] v, input logic prevAddSeg);
    cr0Flags_t f;
    f.pe     = v[B_PE];
    f.addSeg = prevAddSeg | ~v[B_PE];
    f.ts     = v[B_TS];
    f.em     = v[B_EM];
    f.mp     = v[B_MP];
    return f;
  endfunction
endpackage

// File: rtl/ctl_reg_ctrl.sv
module ctl_reg_ctrl
  import ctl_reg_pkg::*;
(
  input  logic            cr0WrEn,
  input  logic [CR_W-1:0] cr0WrData,
  input  logic            cr4WrEn,
  input  logic [CR_W-1:0] cr4WrData,
  input  logic            eferLme,
  input  logic [CR_W-1:0] curCr0,
  input  logic [CR_W-1:0] curCr4,
  input  logic            curLma,
  output crStrobes_t      stb
);
  logic pgOld, pgNew, paeEff, lmRequest, cr0Flush, cr4Flush;

  always_comb begin
    pgOld     = curCr0[B_PG];
    pgNew     = cr0WrData[B_PG];
    // CR4 is applied first, so a same-cycle CR4 write supplies PAE
    paeEff    = cr4WrEn ? cr4WrData[B_PAE] : curCr4[B_PAE];
    lmRequest = cr0WrEn & ~pgOld & pgNew & eferLme;
    cr0Flush  = cr0WrEn &
                ((curCr0[B_PG] ^ cr0WrData[B_PG]) |
                 (curCr0[B_WP] ^ cr0WrData[B_WP]) |
                 (curCr0[B_PE] ^ cr0WrData[B_PE]));
    cr4Flush  = cr4WrEn &
                ((curCr4[B_PGE] ^ cr4WrData[B_PGE]) |
                 (curCr4[B_PAE] ^ cr4WrData[B_PAE]) |
                 (curCr4[B_PSE] ^ cr4WrData[B_PSE]));
    stb.ld4     = cr4WrEn;
    stb.ld0     = cr0WrEn & ~(lmRequest & ~paeEff);
    stb.enterLm = lmRequest & paeEff;
    stb.exitLm  = cr0WrEn & pgOld & ~pgNew & curLma;
    stb.flush   = cr0Flush | cr4Flush;
  end
endmodule

// File: rtl/ctl_reg_dpath.sv
module ctl_reg_dpath
  import ctl_reg_pkg::*;
#(
  parameter int              IP_W      = 64,
  parameter logic [CR_W-1:0] CR0_RESET = 32'h6000_0010
) (
  input  logic            clk,
  input  logic            rstN,
  input  crStrobes_t      stb,
  input  logic [CR_W-1:0] cr0WrData,
  input  logic [CR_W-1:0] cr4WrData,
  input  logic            sseSupported,
  input  logic            csLongSet,
  input  logic [IP_W-1:0] ipIn,
  output logic [CR_W-1:0] cr0Q,
  output logic [CR_W-1:0] cr4Q,
  output cr0Flags_t       flagsQ,
  output logic            osFxsrQ,
  output logic            lmaQ,
  output logic            cs64Q,
  output logic            flushQ,
  output logic            truncQ,
  output logic [IP_W-1:0] truncIpQ
);
  localparam int KEEP_W = (IP_W < 32) ? IP_W : 32;
  localparam logic [CR_W-1:0] ET_MASK  = CR_W'(1) << B_ET;
  localparam logic [CR_W-1:0] FXS_MASK = CR_W'(1) << B_OSFXSR;

  logic [CR_W-1:0] cr0Next, cr4Next;
  logic [IP_W-1:0] ipCut;

  always_comb begin
    cr0Next = cr0WrData | ET_MASK;
    cr4Next = sseSupported ? cr4WrData : (cr4WrData & ~FXS_MASK);
    ipCut   = '0;
    ipCut[KEEP_W-1:0] = ipIn[KEEP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q     <= CR0_RESET | ET_MASK;
      flagsQ   <= deriveFlags(CR0_RESET | ET_MASK, 1'b0);
      cr4Q     <= '0;
      osFxsrQ  <= 1'b0;
      lmaQ     <= 1'b0;
      cs64Q    <= 1'b0;
      flushQ   <= 1'b0;
      truncQ   <= 1'b0;
      truncIpQ <= '0;
    end else begin
      flushQ <= stb.flush;
      truncQ <= stb.exitLm;
      if (stb.ld4) begin
        cr4Q    <= cr4Next;
        osFxsrQ <= cr4Next[B_OSFXSR];
      end
      if (stb.ld0) begin
        cr0Q   <= cr0Next;
        flagsQ <= deriveFlags(cr0Next, flagsQ.addSeg);
      end
      if (stb.enterLm) lmaQ <= 1'b1;
      else if (stb.exitLm) lmaQ <= 1'b0;
      if (stb.exitLm) begin
        cs64Q    <= 1'b0;
        truncIpQ <= ipCut;
      end else if (csLongSet && lmaQ) begin
        cs64Q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_reg_update.sv
module ctl_reg_update
  import ctl_reg_pkg::*;
#(
  parameter int IP_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cr0WrEn,
  input  logic [31:0]     cr0WrData,
  input  logic            cr4WrEn,
  input  logic [31:0]     cr4WrData,
  input  logic            eferLme,
  input  logic            sseSupported,
  input  logic            csLongSet,
  input  logic [IP_W-1:0] ipIn,
  output logic [31:0]     cr0Out,
  output logic [31:0]     cr4Out,
  output logic            peFlag,
  output logic            addSegFlag,
  output logic [2:0]      fpuFlags,
  output logic            osFxsrFlag,
  output logic            lmaFlag,
  output logic            cs64Flag,
  output logic            eferLma,
  output logic            tlbFlush,
  output logic            ipTruncStrobe,
  output logic [IP_W-1:0] ipTruncValue
);
  crStrobes_t stb;
  cr0Flags_t  flags;
  logic       lmaQ;

  ctl_reg_ctrl u_ctrl (
    .cr0WrEn(cr0WrEn), .cr0WrData(cr0WrData),
    .cr4WrEn(cr4WrEn), .cr4WrData(cr4WrData),
    .eferLme(eferLme), .curCr0(cr0Out), .curCr4(cr4Out),
    .curLma(lmaQ), .stb(stb)
  );

  ctl_reg_dpath #(.IP_W(IP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cr0WrData(cr0WrData), .cr4WrData(cr4WrData),
    .sseSupported(sseSupported), .csLongSet(csLongSet), .ipIn(ipIn),
    .cr0Q(cr0Out), .cr4Q(cr4Out), .flagsQ(flags), .osFxsrQ(osFxsrFlag),
    .lmaQ(lmaQ), .cs64Q(cs64Flag), .flushQ(tlbFlush),
    .truncQ(ipTruncStrobe), .truncIpQ(ipTruncValue)
  );

  assign peFlag     = flags.pe;
  assign addSegFlag = flags.addSeg;
  assign fpuFlags   = {flags.ts, flags.em, flags.mp};
  assign lmaFlag    = lmaQ;
  assign eferLma    = lmaQ;
endmodule

// File: rtl/ctl_reg_update_chk.sv
module ctl_reg_update_chk #(
  parameter int IP_W = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            cr0WrEn,
  input logic            cr4WrEn,
  input logic            sseSupported,
  input logic            csLongSet,
  input logic [31:0]     cr0Out,
  input logic [31:0]     cr4Out,
  input logic            peFlag,
  input logic            addSegFlag,
  input logic            osFxsrFlag,
  input logic            cs64Flag,
  input logic            eferLma,
  input logic            tlbFlush,
  input logic            ipTruncStrobe,
  input logic [IP_W-1:0] ipTruncValue
);
  AST_ET_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    cr0Out[4]); // R2
  AST_PE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    peFlag == cr0Out[0]); // R3
  AST_REAL_ADDSEG: assert property (@(posedge clk) disable iff (!rstN)
    !peFlag |-> addSegFlag); // R3
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> $past(cr0WrEn || cr4WrEn)); // R5
  AST_FXSR_STRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cr4WrEn && !sseSupported) |=> !osFxsrFlag); // R7
  AST_FXSR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    osFxsrFlag == cr4Out[9]); // R7
  AST_LMA_NEEDS_PAE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eferLma) |-> (cr4Out[5] && cr0Out[31])); // R8
  AST_TRUNC_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ipTruncStrobe |-> (!eferLma && !cs64Flag && ipTruncValue[IP_W-1:32] == '0)); // R10
  AST_CS64_IN_LM: assert property (@(posedge clk) disable iff (!rstN)
    cs64Flag |-> eferLma); // R12
endmodule

bind ctl_reg_update ctl_reg_update_chk #(.IP_W(IP_W)) u_chk (
  .clk(clk), .rstN(rstN), .cr0WrEn(cr0WrEn), .cr4WrEn(cr4WrEn),
  .sseSupported(sseSupported), .csLongSet(csLongSet),
  .cr0Out(cr0Out), .cr4Out(cr4Out), .peFlag(peFlag), .addSegFlag(addSegFlag),
  .osFxsrFlag(osFxsrFlag), .cs64Flag(cs64Flag), .eferLma(eferLma),
  .tlbFlush(tlbFlush), .ipTruncStrobe(ipTruncStrobe), .ipTruncValue(ipTruncValue)
);

// File: tb/tb_ctl_reg_update.sv
module tb_ctl_reg_update;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cr0WrEn = 1'b0, cr4WrEn = 1'b0;
  logic [31:0] cr0WrData = '0, cr4WrData = '0;
  logic        eferLme = 1'b0, sseSupported = 1'b1, csLongSet = 1'b0;
  logic [63:0] ipIn = '0;
  logic [31:0] cr0Out, cr4Out;
  logic        peFlag, addSegFlag, osFxsrFlag, lmaFlag, cs64Flag, eferLma;
  logic        tlbFlush, ipTruncStrobe;
  logic [2:0]  fpuFlags;
  logic [63:0] ipTruncValue;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctl_reg_update #(.IP_W(64)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write cycle; returns at the negedge after the accepting edge
  task automatic wr(input logic e0, input logic [31:0] d0, input logic e4, input logic [31:0] d4);
    cr0WrEn = e0; cr0WrData = d0; cr4WrEn = e4; cr4WrData = d4;
    @(negedge clk);
    cr0WrEn = 1'b0; cr4WrEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cr0", cr0Out, 32'h6000_0010);
    chk("R1 cr4", cr4Out, 0);
    chk("R1 pe", peFlag, 0);
    chk("R1 addSeg", addSegFlag, 1);
    chk("R1 fpu", fpuFlags, 0);
    chk("R1 osfx", osFxsrFlag, 0);
    chk("R1 lma", eferLma, 0);
    chk("R1 cs64", cs64Flag, 0);
    chk("R1 flush", tlbFlush, 0);
    chk("R1 trunc", ipTruncStrobe, 0);
  endtask

  task automatic t_fpu();
    wr(1, 32'h0000_000E, 0, 0);
    chk("R2 et forced", cr0Out, 32'h0000_001E);
    chk("R4 fpu all", fpuFlags, 3'b111);
    chk("R5 no flush", tlbFlush, 0);
    wr(1, 32'h0000_000A, 0, 0);
    chk("R4 fpu ts mp", fpuFlags, 3'b101);
    chk("R2 et again", cr0Out, 32'h0000_001A);
  endtask

  task automatic t_pe();
    wr(1, 32'h0000_0001, 0, 0);
    chk("R3 pe set", peFlag, 1);
    chk("R3 addSeg held", addSegFlag, 1);
    chk("R5 flush pe", tlbFlush, 1);
    @(negedge clk);
    chk("R5 flush one cycle", tlbFlush, 0);
    wr(1, 32'h0000_0000, 0, 0);
    chk("R3 pe clear", peFlag, 0);
    chk("R3 addSeg real", addSegFlag, 1);
    wr(1, 32'h0001_0000, 0, 0);
    chk("R5 flush wp", tlbFlush, 1);
    chk("R5 cr0 wp", cr0Out, 32'h0001_0010);
  endtask

  task automatic t_cr4();
    wr(0, 0, 1, 32'h0000_0080);
    chk("R6 flush pge", tlbFlush, 1);
    chk("R6 cr4", cr4Out, 32'h80);
    wr(0, 0, 1, 32'h0000_0081);
    chk("R6 no flush", tlbFlush, 0);
    sseSupported = 1'b1;
    wr(0, 0, 1, 32'h0000_0280);
    chk("R7 osfx kept", cr4Out, 32'h280);
    chk("R7 osfx flag", osFxsrFlag, 1);
    sseSupported = 1'b0;
    wr(0, 0, 1, 32'h0000_0280);
    chk("R7 osfx masked", cr4Out, 32'h80);
    chk("R7 osfx flag off", osFxsrFlag, 0);
    sseSupported = 1'b1;
  endtask

  task automatic t_lm_reject();
    eferLme = 1'b1;
    wr(1, 32'h8000_0001, 0, 0);
    chk("R9 cr0 unchanged", cr0Out, 32'h0001_0010);
    chk("R9 pe unchanged", peFlag, 0);
    chk("R9 lma stays", eferLma, 0);
    chk("R9 flush still", tlbFlush, 1);
  endtask

  task automatic t_lm_same_cycle();
    wr(1, 32'h8000_0001, 1, 32'h0000_00A0);
    chk("R11 lma", eferLma, 1);
    chk("R11 lmaFlag", lmaFlag, 1);
    chk("R11 cr0", cr0Out, 32'h8000_0011);
    chk("R11 cr4", cr4Out, 32'hA0);
  endtask

  task automatic t_cs64_and_exit();
    csLongSet = 1'b1; @(negedge clk); csLongSet = 1'b0;
    chk("R12 cs64 set", cs64Flag, 1);
    ipIn = 64'h1234_5678_9ABC_DEF0;
    wr(1, 32'h0000_0001, 0, 0);
    chk("R10 lma cleared", eferLma, 0);
    chk("R10 cs64 cleared", cs64Flag, 0);
    chk("R10 strobe", ipTruncStrobe, 1);
    chk("R10 value", ipTruncValue, 64'h0000_0000_9ABC_DEF0);
    @(negedge clk);
    chk("R10 strobe one cycle", ipTruncStrobe, 0);
    csLongSet = 1'b1; @(negedge clk); csLongSet = 1'b0;
    chk("R12 cs64 ignored", cs64Flag, 0);
  endtask

  task automatic t_lm_entry();
    eferLme = 1'b0;
    wr(1, 32'h8000_0001, 0, 0);
    chk("R8 no lme", eferLma, 0);
    chk("R8 cr0 taken", cr0Out, 32'h8000_0011);
    wr(1, 32'h0000_0001, 0, 0);
    chk("R10 no strobe without lma", ipTruncStrobe, 0);
    eferLme = 1'b1;
    wr(1, 32'h8000_0001, 0, 0);
    chk("R8 entry pae", eferLma, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fpu();
    t_pe();
    t_cr4();
    t_lm_reject();
    t_lm_same_cycle();
    t_cs64_and_exit();
    t_lm_entry();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule